// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block is the counting core of a pulse-width modulator channel. A W-bit counter advances once per prescaled tick of the system clock. It can count up and wrap, count down and reload, count up and down in a triangle, or hold still. Two one-cycle strobes mark the counter reaching zero and reaching the programmed period. Later compare and waveform stages key their edges from these strobes and from the count.

Several instances can be chained so that they run in step. Each instance takes a sync input pulse, and software can also force a sync by writing the control word. On a sync, an instance may overwrite its count with a programmed phase offset. In triangle mode it can also be told which way to count next. This gives a fixed lead or lag between channels. A selectable sync output feeds the next instance in the chain: either the incoming sync passed on, a pulse at each zero count, or nothing. A global time-base enable input stops the prescaled clock of every instance. When the enable rises, all prescalers restart from the same point, so instances with equal divider settings tick together.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction flag `cnt_up` is 1, and `evt_zero`, `evt_prd` and `sync_out` are 0. Control, period and phase reset to 0.
- R2: While `tb_en` is high, the counter takes one step per tick. A tick occurs every (div+1) clock cycles, where div is control bits [8:6].
- R3: While `tb_en` is low, the counter and the prescaler hold. The first clock edge at which `tb_en` is sampled high restarts the prescaler from zero, so the first step happens on the (div+1)-th such edge.
- R4: Mode 0 (control bits [1:0] = 0) counts up from 0 to the period, then wraps to 0, with `cnt_up` = 1.
- R5: Mode 1 counts down and reloads the period after 0, with `cnt_up` = 0.
- R6: Mode 2 counts up to the period, then down to 0, then up again. `cnt_up` shows the current direction, and each end value is held for one step.
- R7: Mode 3 holds the count and produces no `evt_zero` or `evt_prd` strobes.
- R8: `evt_zero` and `evt_prd` are high for exactly the one clock cycle that follows each step landing on 0 or on the period.
- R9: With phase-enable (control bit 2) set, a sync loads the phase register into the count on the next tick. A sync arriving between ticks is held pending until that tick.
- R10: Writing control with bit 9 set produces a one-cycle internal sync, one clock later, with the same effect as a `sync_in` pulse. The other control bits are written as usual.
- R11: In mode 2, a phase load sets the direction to control bit 3 (1 = up), whatever the direction was before. In modes 0 and 1, bit 3 has no effect.
- R12: With phase-enable clear, a sync leaves the counting sequence unchanged.
- R13: Control bits [5:4] select `sync_out`. Value 0 pulses on the tick that consumes a sync, whatever the phase-enable setting. Value 1 pulses with each step to 0 outside mode 3. Values 2 and 3 never pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 phase |
| wr_data | input | W | Write data |
| sync_in | input | 1 | External sync pulse |
| tb_en | input | 1 | Global time-base enable |
| sync_out | output | 1 | Sync pulse to the next instance |
| cnt | output | W | Current count |
| cnt_up | output | 1 | Count direction, 1 = up |
| evt_zero | output | 1 | Count-reached-zero strobe |
| evt_prd | output | 1 | Count-reached-period strobe |

## Verification
Some properties are checked by assertions on every cycle:
- the count holds while `tb_en` is low or the mode is frozen;
- each strobe matches the count it reports;
- strobes appear only after a prescaler tick;
- `sync_out` stays silent when its source is off.

Other behaviour needs the bench's scenarios and its reference model:
- the exact step sequences in each mode;
- tick alignment after an enable rise;
- a pending sync waiting for a slow tick;
- the phase-direction override;
- the one-cycle delay of a forced sync.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    localparam int DIV_W = 3;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDN   = 2'd2,
        MODE_FREEZE = 2'd3
    } tb_mode_e;

    typedef enum logic [1:0] {
        SO_PASS = 2'd0,
        SO_ZERO = 2'd1,
        SO_OFF  = 2'd2,
        SO_OFF3 = 2'd3
    } so_sel_e;

    // Control word layout, LSB first: mode[1:0], phase enable[2],
    // phase direction[3], sync-out select[5:4], divider[8:6]
    typedef struct packed {
        logic [DIV_W-1:0] div;
        so_sel_e          so_sel;
        logic             ph_dir;
        logic             ph_en;
        tb_mode_e         mode;
    } tb_ctrl_t;

    localparam int CTRL_W    = $bits(tb_ctrl_t);
    localparam int FSYNC_BIT = CTRL_W;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PRD  = 2'd1;
    localparam logic [1:0] ADDR_PHS  = 2'd2;
endpackage

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
    import pwm_tb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output tb_ctrl_t     ctrl,
    output logic [W-1:0] prd,
    output logic [W-1:0] phs,
    output logic         fsync
);
    typedef struct packed {
        tb_ctrl_t     ctrl;
        logic [W-1:0] prd;
        logic [W-1:0] phs;
        logic         fsync;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.fsync = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    s_d.ctrl  = tb_ctrl_t'(wr_data[CTRL_W-1:0]);
                    s_d.fsync = wr_data[FSYNC_BIT];
                end
                ADDR_PRD: s_d.prd = wr_data;
                ADDR_PHS: s_d.phs = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl  = s_q.ctrl;
    assign prd   = s_q.prd;
    assign phs   = s_q.phs;
    assign fsync = s_q.fsync;
endmodule

// File: rtl/pwm_tb_presc.sv
module pwm_tb_presc #(
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          tick
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          en;
    } presc_t;

    presc_t s_d, s_q;
    logic [DW-1:0] cnt_eff;

    always_comb begin
        s_d     = s_q;
        s_d.en  = en;
        // restart the divider on the first enabled edge
        cnt_eff = (en && !s_q.en) ? '0 : s_q.cnt;
        tick    = en && (cnt_eff == div);
        if (en) s_d.cnt = tick ? '0 : cnt_eff + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_tb_core.sv
module pwm_tb_core
    import pwm_tb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         sync_any,
    input  tb_mode_e     mode,
    input  logic         ph_en,
    input  logic         ph_dir,
    input  so_sel_e      so_sel,
    input  logic [W-1:0] prd,
    input  logic [W-1:0] phs,
    output logic [W-1:0] cnt,
    output logic         up,
    output logic         evt_zero,
    output logic         evt_prd,
    output logic         sync_out
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic         pend;
        logic         ez;
        logic         ep;
        logic         so;
    } core_t;

    core_t s_d, s_q;
    logic  sync_now;
    logic  frozen;

    always_comb begin
        s_d      = s_q;
        s_d.ez   = 1'b0;
        s_d.ep   = 1'b0;
        s_d.so   = 1'b0;
        sync_now = s_q.pend | sync_any;
        frozen   = (mode == MODE_FREEZE);
        s_d.pend = tick ? 1'b0 : sync_now;
        if (tick) begin
            if (frozen) begin
                s_d.cnt = s_q.cnt;
            end else if (sync_now && ph_en) begin
                s_d.cnt = phs;
                s_d.up  = (mode == MODE_UPDN) ? ph_dir : (mode == MODE_UP);
            end else begin
                unique case (mode)
                    MODE_UP: begin
                        s_d.up  = 1'b1;
                        s_d.cnt = (s_q.cnt >= prd) ? '0 : s_q.cnt + ONE;
                    end
                    MODE_DOWN: begin
                        s_d.up  = 1'b0;
                        s_d.cnt = (s_q.cnt == '0) ? prd : s_q.cnt - ONE;
                    end
                    default: begin
                        if (s_q.up) begin
                            if (s_q.cnt >= prd) begin
                                s_d.up  = 1'b0;
                                s_d.cnt = (s_q.cnt == '0) ? '0 : s_q.cnt - ONE;
                            end else begin
                                s_d.cnt = s_q.cnt + ONE;
                            end
                        end else begin
                            if (s_q.cnt == '0) begin
                                s_d.up  = 1'b1;
                                s_d.cnt = (prd == '0) ? '0 : ONE;
                            end else begin
                                s_d.cnt = s_q.cnt - ONE;
                            end
                        end
                    end
                endcase
            end
            s_d.ez = !frozen && (s_d.cnt == '0);
            s_d.ep = !frozen && (s_d.cnt == prd);
            unique case (so_sel)
                SO_PASS: s_d.so = sync_now;
                SO_ZERO: s_d.so = !frozen && (s_d.cnt == '0);
                default: s_d.so = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, up: 1'b1, default: 1'b0};
        else        s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    assign up       = s_q.up;
    assign evt_zero = s_q.ez;
    assign evt_prd  = s_q.ep;
    assign sync_out = s_q.so;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         sync_in,
    input  logic         tb_en,
    output logic         sync_out,
    output logic [W-1:0] cnt,
    output logic         cnt_up,
    output logic         evt_zero,
    output logic         evt_prd
);
    tb_ctrl_t     ctrl;
    logic [W-1:0] prd;
    logic [W-1:0] phs;
    logic         fsync;
    logic         tick;

    pwm_tb_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .prd(prd), .phs(phs), .fsync(fsync)
    );

    pwm_tb_presc #(.DW(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(tb_en), .div(ctrl.div), .tick(tick)
    );

    pwm_tb_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sync_any(sync_in | fsync),
        .mode(ctrl.mode), .ph_en(ctrl.ph_en), .ph_dir(ctrl.ph_dir),
        .so_sel(ctrl.so_sel), .prd(prd), .phs(phs),
        .cnt(cnt), .up(cnt_up), .evt_zero(evt_zero), .evt_prd(evt_prd),
        .sync_out(sync_out)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tb_en,
    input logic         tick,
    input logic [1:0]   mode,
    input logic [1:0]   so_sel,
    input logic [W-1:0] prd,
    input logic [W-1:0] cnt,
    input logic         evt_zero,
    input logic         evt_prd,
    input logic         sync_out
);
    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_en |=> $stable(cnt));

    p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> $stable(cnt));

    p_zero_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_zero |-> (cnt == '0));

    p_prd_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_prd |-> (cnt == $past(prd)));

    p_strobe_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_zero || evt_prd) |-> $past(tick));

    p_sync_out_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> !$past(so_sel[1]));
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .tick(tick),
    .mode(ctrl.mode), .so_sel(ctrl.so_sel), .prd(prd), .cnt(cnt),
    .evt_zero(evt_zero), .evt_prd(evt_prd), .sync_out(sync_out)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         sync_in = 1'b0;
    logic         tb_en = 1'b0;
    logic         sync_out, cnt_up, evt_zero, evt_prd;
    logic [W-1:0] cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_timebase #(.W(W)) u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .tb_en(tb_en),
        .sync_out(sync_out), .cnt(cnt), .cnt_up(cnt_up),
        .evt_zero(evt_zero), .evt_prd(evt_prd)
    );

    // ---------------- reference model built from the requirements
    logic [8:0]   m_ctrl;
    logic [W-1:0] m_prd, m_phs, m_cnt;
    logic [2:0]   m_pcnt;
    logic         m_fs, m_en_q, m_up, m_pend, m_ez, m_ep, m_so;
    logic [2:0]   t_pc;
    logic         t_tk, t_sn, t_nu, t_ez;
    logic [W-1:0] t_nc;
    logic [1:0]   t_md;

    function automatic logic [W:0] next_step(input logic [1:0] md, input logic [W-1:0] c,
                                             input logic u, input logic [W-1:0] p);
        if (md == 2'd0) return {1'b1, (c >= p) ? W'(0) : W'(c + 1)};
        if (md == 2'd1) return {1'b0, (c == 0) ? p : W'(c - 1)};
        if (u) begin
            if (c >= p) return {1'b0, (c == 0) ? W'(0) : W'(c - 1)};
            return {1'b1, W'(c + 1)};
        end
        if (c == 0) return {1'b1, (p == 0) ? W'(0) : W'(1)};
        return {1'b0, W'(c - 1)};
    endfunction

    function automatic logic [W-1:0] ctl(input logic [1:0] md, input logic pe, input logic pd,
                                         input logic [1:0] so, input logic [2:0] dv,
                                         input logic fs);
        return W'({fs, dv, so, pd, pe, md});
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= '0; m_prd <= '0; m_phs <= '0; m_fs <= 1'b0;
            m_pcnt <= '0; m_en_q <= 1'b0; m_cnt <= '0; m_up <= 1'b1;
            m_pend <= 1'b0; m_ez <= 1'b0; m_ep <= 1'b0; m_so <= 1'b0;
        end else begin
            t_pc = (tb_en && !m_en_q) ? 3'd0 : m_pcnt;
            t_tk = tb_en && (t_pc == m_ctrl[8:6]);
            if (tb_en) m_pcnt <= t_tk ? 3'd0 : t_pc + 3'd1;
            m_en_q <= tb_en;
            t_sn = m_pend | sync_in | m_fs;
            m_pend <= t_tk ? 1'b0 : t_sn;
            t_nc = m_cnt; t_nu = m_up; t_ez = 1'b0;
            m_ez <= 1'b0; m_ep <= 1'b0; m_so <= 1'b0;
            if (t_tk) begin
                t_md = m_ctrl[1:0];
                if (t_md == 2'd3) begin
                    t_nc = m_cnt;
                end else if (t_sn && m_ctrl[2]) begin
                    t_nc = m_phs;
                    t_nu = (t_md == 2'd2) ? m_ctrl[3] : (t_md == 2'd0);
                end else begin
                    {t_nu, t_nc} = next_step(t_md, m_cnt, m_up, m_prd);
                end
                t_ez = (t_md != 2'd3) && (t_nc == 0);
                m_ez <= t_ez;
                m_ep <= (t_md != 2'd3) && (t_nc == m_prd);
                m_so <= (m_ctrl[5:4] == 2'd0) ? t_sn : (m_ctrl[5:4] == 2'd1) ? t_ez : 1'b0;
            end
            m_cnt <= t_nc; m_up <= t_nu;
            m_fs <= wr_en && (wr_addr == 2'd0) && wr_data[9];
            if (wr_en && wr_addr == 2'd0) m_ctrl <= wr_data[8:0];
            if (wr_en && wr_addr == 2'd1) m_prd <= wr_data;
            if (wr_en && wr_addr == 2'd2) m_phs <= wr_data;
        end
    end

    // ---------------- checking and stimulus helpers
    task automatic check(input string tag, input logic [W+3:0] got, input logic [W+3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (cnt,up,ez,ep,so)", tag, got, exp);
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        check(tag, {cnt, cnt_up, evt_zero, evt_prd, sync_out},
                   {m_cnt, m_up, m_ez, m_ep, m_so});
        wr_en = 1'b0;
        sync_in = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        step(tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic pulse(input string tag);
        step(tag);
        sync_in = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [W-1:0] held;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, literal and model
        step("R1");
        check("R1", {cnt, cnt_up, evt_zero, evt_prd, sync_out}, {W'(0), 4'b1000});

        // R3: time base stopped while enable low
        write(2'd1, W'(5), "R3");
        write(2'd0, ctl(2'd0, 0, 0, 2'd2, 3'd0, 0), "R3");
        run(5, "R3");
        check("R3", cnt, W'(0));
        tb_en = 1'b1;
        run(16, "R4");                                  // R4 up mode, strobes R8
        write(2'd0, ctl(2'd1, 0, 0, 2'd1, 3'd0, 0), "R5");
        run(16, "R5");                                  // R5 down mode, R13 zero source
        write(2'd0, ctl(2'd2, 0, 0, 2'd0, 3'd0, 0), "R6");
        run(20, "R6");                                  // R6 triangle

        // R2/R3: divider, enable drop and realignment
        write(2'd0, ctl(2'd2, 0, 0, 2'd0, 3'd3, 0), "R2");
        run(14, "R2");
        tb_en = 1'b0;
        run(4, "R3");
        tb_en = 1'b1;
        run(12, "R3");

        // R7: frozen
        write(2'd0, ctl(2'd3, 0, 0, 2'd1, 3'd0, 0), "R7");
        step("R7");
        held = cnt;
        run(8, "R7");
        check("R7", {cnt, evt_zero, evt_prd}, {held, 2'b00});

        // R9/R11: phase load in triangle, direction forced down
        write(2'd2, W'(2), "R9");
        write(2'd0, ctl(2'd2, 1, 0, 2'd0, 3'd0, 0), "R9");
        run(3, "R9");
        pulse("R9");
        step("R11");
        check("R11", {cnt, cnt_up, sync_out}, {W'(2), 1'b0, 1'b1});
        run(6, "R11");
        // R11: direction bit ignored in up mode
        write(2'd0, ctl(2'd0, 1, 0, 2'd0, 3'd0, 0), "R11");
        pulse("R11");
        step("R11");
        check("R11", {cnt, cnt_up}, {W'(2), 1'b1});
        run(4, "R11");
        // R9: pending sync waits for a slow tick
        write(2'd0, ctl(2'd0, 1, 0, 2'd0, 3'd5, 0), "R9");
        pulse("R9");
        run(14, "R9");
        // R12: phase disabled, sync still passed out
        write(2'd0, ctl(2'd0, 0, 0, 2'd0, 3'd0, 0), "R12");
        pulse("R12");
        run(6, "R12");
        // R10: forced sync through the control write
        write(2'd0, ctl(2'd2, 1, 1, 2'd0, 3'd0, 1), "R10");
        step("R10");
        step("R10");
        check("R10", {cnt, cnt_up, sync_out}, {W'(2), 1'b1, 1'b1});
        run(4, "R10");
        // R13: sync-out disabled
        write(2'd0, ctl(2'd0, 1, 0, 2'd3, 3'd0, 0), "R13");
        pulse("R13");
        run(6, "R13");

        // random mix, checked each cycle against the model (R8 strobes throughout)
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8)       write(2'd0, W'({($urandom_range(0, 7) == 0), 9'($urandom)}), "R8");
            else if (r < 14) write(2'd1, W'($urandom_range(0, 12)), "R8");
            else if (r < 20) write(2'd2, W'($urandom_range(0, 15)), "R9");
            else if (r < 28) pulse("R9");
            else if (r < 31) begin step("R3"); tb_en = ~tb_en; end
            else             step("R8");
        end
        tb_en = 1'b1;
        run(4, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule